// File: doc/BRIEF.md
# Power-Loss Lockout Controller

This block protects a battery-backed device when main power is about to fail. An early-warning input from a power monitor goes low before the supply collapses. The block then raises an interrupt so firmware can save its state, and it arms a lockout in one of two ways: firmware writes a lock command register, or a watchdog driven by a slow time base runs out. Once armed, the block either locks out at once or, when DRAM self-refresh from battery is in use, waits for a cycle in which no main-power refresh is running. In lockout the battery-domain reset is driven, battery refresh mode is signalled when DRAM was enabled, and the block stays frozen until the next power-on reset.

Two sticky status flags can be read as outputs. One records that the battery-reset pin was seen low. The other records that a lock enable happened, whether from software or from the watchdog. Firmware clears a flag by writing 1 to its bit in the configuration register. The register interface is a plain one-cycle write strobe with address and data. It has no handshake, because every write completes in the cycle it is presented.

Top module: `pwrloss_lockout`

## Requirements
- R1: One synchronised cycle after the warning input falls (two synchroniser stages, then an edge detector), `sys_irq` goes high unless lockout is being entered in that cycle.
- R2: A write to the lock command address (default 1) arms the lockout, whatever data is written.
- R3: When armed with `dram_en` low, `lockout` goes high in the cycle after arming.
- R4: When armed with `dram_en` high, `lockout` does not rise in any cycle where `refresh_busy` was high. It rises one cycle after `refresh_busy` is sampled low.
- R5: Lockout is sticky until reset. During lockout `bat_rst_n` is low, `sys_irq` is low, and `bat_refresh` equals the value `dram_en` had when lockout was entered.
- R6: Once the warning has been latched and no lock write has arrived, the block arms itself on the TIMEOUT_TICKS-th `slow_tick` pulse (default 12).
- R7: `stat_batrst` (configuration bit 12) is set while the synchronised battery-reset pin is low.
- R8: `stat_lockev` (configuration bit 11) is set when arming happens, from either software or the watchdog.
- R9: A write to the configuration address (default 3) clears only the status bits written as 1. Bits written as 0 are unchanged, and setting wins over clearing in the same cycle.
- R10: `sys_irq` stays high until a write to the acknowledge address (default 2) or until lockout is entered.
- R11: All register writes are ignored during lockout.
- R12: After reset, `sys_irq`, `lockout`, `bat_refresh`, `stat_batrst` and `stat_lockev` are 0 and `bat_rst_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| pwr_warn_n | input | 1 | Early power-loss warning, active low, asynchronous |
| bat_pin_n | input | 1 | Battery-reset pin, active low, asynchronous |
| slow_tick | input | 1 | One-cycle pulse from the slow time base (about 8 Hz) |
| dram_en | input | 1 | DRAM kept in battery refresh |
| refresh_busy | input | 1 | A main-power refresh cycle is in progress |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| sys_irq | output | 1 | Power-loss interrupt request |
| lockout | output | 1 | Lockout active |
| bat_refresh | output | 1 | Battery refresh mode |
| bat_rst_n | output | 1 | Battery-domain reset, active low |
| stat_batrst | output | 1 | Sticky flag: battery reset seen |
| stat_lockev | output | 1 | Sticky flag: lock enable occurred |

## Verification
The main function is driven along three routes into lockout. The first is a software lock with DRAM off, which shows that lockout is immediate. The second is a software lock with DRAM on and refresh held busy, which shows the wait for a refresh gap. The third has no lock write at all, so only the watchdog can arm the block, and it checks that arming happens on the right tick. Separate runs pulse the battery-reset pin and write clear patterns of 0, 1 and mixed bits, which separates bit-selective clearing from whole-register clearing. Writes are also issued after lockout to show they are ignored. A behavioural model tracks every output on every clock, so an off-by-one in the synchroniser delay or the tick count shows up as a mismatch.

// File: rtl/plc_pkg.sv
package plc_pkg;
  localparam int unsigned ADDR_LOCK_DEF = 1;
  localparam int unsigned ADDR_ACK_DEF  = 2;
  localparam int unsigned ADDR_CFG_DEF  = 3;
  localparam int unsigned BIT_BATRST    = 12;
  localparam int unsigned BIT_LOCKEV    = 11;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ARMED = 2'd1,
    ST_LOCK  = 2'd2
  } plc_state_e;
endpackage

// File: rtl/plc_sync.sv
module plc_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '1;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/plc_timeout.sv
module plc_timeout #(
  parameter int unsigned TICKS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam int unsigned CW = (TICKS < 2) ? 1 : $clog2(TICKS);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (run && tick && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expire = run && tick && (cnt == LAST);

  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));
endmodule

// File: rtl/plc_w1c.sv
module plc_w1c #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[i] <= 1'b0;
        else if (set[i]) q[i] <= 1'b1;
        else if (clr[i]) q[i] <= 1'b0;
      end

      a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[i] && !set[i]) |=> !q[i]);
      a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr[i] && !set[i]) |=> $stable(q[i]));
    end
  endgenerate
endmodule

// File: rtl/pwrloss_lockout.sv
module pwrloss_lockout
  import plc_pkg::*;
#(
  parameter int unsigned ADDR_W        = 4,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned TIMEOUT_TICKS = 12,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned ADDR_LOCK     = ADDR_LOCK_DEF,
  parameter int unsigned ADDR_ACK      = ADDR_ACK_DEF,
  parameter int unsigned ADDR_CFG      = ADDR_CFG_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_warn_n,
  input  logic              bat_pin_n,
  input  logic              slow_tick,
  input  logic              dram_en,
  input  logic              refresh_busy,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              sys_irq,
  output logic              lockout,
  output logic              bat_refresh,
  output logic              bat_rst_n,
  output logic              stat_batrst,
  output logic              stat_lockev
);
  localparam int unsigned NST = 2;

  plc_state_e state;
  logic [1:0] sync_q;
  logic       warn_s, warn_q, bat_s;
  logic       pd_latched, keep_dram;
  logic       wr_ok, wr_lock, wr_ack, wr_cfg;
  logic       tmo, arm_evt, lock_go, fall;
  logic [NST-1:0] st_set, st_clr, st_q;

  plc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d({bat_pin_n, pwr_warn_n}), .q(sync_q));
  assign warn_s = sync_q[0];
  assign bat_s  = sync_q[1];

  assign lockout = (state == ST_LOCK);
  assign wr_ok   = wr_en && !lockout;
  assign wr_lock = wr_ok && (wr_addr == ADDR_W'(ADDR_LOCK));
  assign wr_ack  = wr_ok && (wr_addr == ADDR_W'(ADDR_ACK));
  assign wr_cfg  = wr_ok && (wr_addr == ADDR_W'(ADDR_CFG));
  assign fall    = warn_q && !warn_s;

  plc_timeout #(.TICKS(TIMEOUT_TICKS)) i_tmo (
    .clk(clk), .rst_n(rst_n),
    .run(pd_latched && state == ST_RUN), .tick(slow_tick), .expire(tmo));

  assign arm_evt = (state == ST_RUN) && (wr_lock || tmo);
  assign lock_go = (state == ST_ARMED) && (!dram_en || !refresh_busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_RUN;
      warn_q     <= 1'b1;
      pd_latched <= 1'b0;
      keep_dram  <= 1'b0;
      sys_irq    <= 1'b0;
    end else begin
      warn_q <= warn_s;
      if (!lockout && !warn_s) pd_latched <= 1'b1;
      case (state)
        ST_RUN:   if (arm_evt) state <= ST_ARMED;
        ST_ARMED: if (lock_go) begin
                    state     <= ST_LOCK;
                    keep_dram <= dram_en;
                  end
        default:  state <= ST_LOCK;
      endcase
      if (lockout || lock_go) sys_irq <= 1'b0;
      else if (fall)          sys_irq <= 1'b1;
      else if (wr_ack)        sys_irq <= 1'b0;
    end
  end

  assign st_set = {!bat_s, arm_evt};
  assign st_clr = {wr_cfg && wr_data[BIT_BATRST], wr_cfg && wr_data[BIT_LOCKEV]};

  plc_w1c #(.N(NST)) i_status (
    .clk(clk), .rst_n(rst_n), .set(st_set), .clr(st_clr), .q(st_q));

  assign stat_batrst = st_q[1];
  assign stat_lockev = st_q[0];
  assign bat_refresh = lockout && keep_dram;
  assign bat_rst_n   = !lockout;

  a_r1_irq_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !lockout && !lock_go) |=> sys_irq);
  a_r3_no_dram_now: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED && !dram_en) |=> lockout);
  a_r4_refresh_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lockout) |-> ($past(!dram_en) || $past(!refresh_busy)));
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |=> (lockout && !sys_irq && !bat_rst_n));
  a_r8_lockev: assert property (@(posedge clk) disable iff (!rst_n)
    arm_evt |=> stat_lockev);
  a_r10_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_irq && !wr_ack && !lock_go) |=> sys_irq);
  a_r11_locked_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (lockout && stat_lockev) |=> stat_lockev);
endmodule

// File: tb/test_pwrloss_lockout.sv
module test_pwrloss_lockout;
  localparam int TO = 12;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_warn_n = 1'b1, bat_pin_n = 1'b1, slow_tick = 1'b0;
  logic dram_en = 1'b0, refresh_busy = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic sys_irq, lockout, bat_refresh, bat_rst_n, stat_batrst, stat_lockev;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit tick_on = 1'b0, cmp_en = 1'b0;

  // behavioural reference state
  bit m_w1, m_w2, m_wq, m_b1, m_b2, m_pd, m_arm, m_lock, m_keep, m_irq, m_sb, m_sl;
  int m_cnt;

  pwrloss_lockout #(.TIMEOUT_TICKS(TO)) i_pwrloss_lockout (
    .clk(clk), .rst_n(rst_n), .pwr_warn_n(pwr_warn_n), .bat_pin_n(bat_pin_n),
    .slow_tick(slow_tick), .dram_en(dram_en), .refresh_busy(refresh_busy),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sys_irq(sys_irq),
    .lockout(lockout), .bat_refresh(bat_refresh), .bat_rst_n(bat_rst_n),
    .stat_batrst(stat_batrst), .stat_lockev(stat_lockev));

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      {m_w1, m_w2, m_wq, m_b1, m_b2} = '1;
      {m_pd, m_arm, m_lock, m_keep, m_irq, m_sb, m_sl} = '0;
      m_cnt = 0;
      cmp_en = 1'b0;
    end else begin
      bit wl, wa, wc, fl, tm, ae, go;
      wl = wr_en && !m_lock && wr_addr == 4'd1;
      wa = wr_en && !m_lock && wr_addr == 4'd2;
      wc = wr_en && !m_lock && wr_addr == 4'd3;
      fl = m_wq && !m_w2;
      tm = m_pd && !m_arm && !m_lock && slow_tick && m_cnt == TO - 1;
      ae = !m_arm && !m_lock && (wl || tm);
      go = m_arm && !m_lock && (!dram_en || !refresh_busy);
      if (m_pd && !m_arm && !m_lock && slow_tick && m_cnt < TO - 1) m_cnt++;
      if (m_lock || go) m_irq = 0; else if (fl) m_irq = 1; else if (wa) m_irq = 0;
      if (!m_b2) m_sb = 1; else if (wc && wr_data[12]) m_sb = 0;
      if (ae) m_sl = 1; else if (wc && wr_data[11]) m_sl = 0;
      if (!m_lock && !m_w2) m_pd = 1;
      if (ae) m_arm = 1;
      if (go) begin m_lock = 1; m_keep = dram_en; end
      m_wq = m_w2; m_w2 = m_w1; m_w1 = pwr_warn_n;
      m_b2 = m_b1; m_b1 = bat_pin_n;
      cmp_en = 1'b1;
    end
  end

  always @(negedge clk) begin
    slow_tick = tick_on && (cyc % 8 == 0);
    if (cmp_en) begin
      n_run++;
      if ({sys_irq, lockout, bat_refresh, bat_rst_n, stat_batrst, stat_lockev} !==
          {m_irq, m_lock, m_lock && m_keep, !m_lock, m_sb, m_sl}) begin
        n_fail++;
        $display("FAIL R1 R2 R5 R7 R8 model: actual %b expected %b at cycle %0d",
          {sys_irq, lockout, bat_refresh, bat_rst_n, stat_batrst, stat_lockev},
          {m_irq, m_lock, m_lock && m_keep, !m_lock, m_sb, m_sl}, cyc);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; pwr_warn_n = 1; bat_pin_n = 1; dram_en = 0; refresh_busy = 0;
    tick_on = 0; wr_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R12 reset state
    do_reset(); idle(1);
    chk("R12 irq", sys_irq, 0); chk("R12 lockout", lockout, 0);
    chk("R12 bat_rst_n", bat_rst_n, 1); chk("R12 stat_lockev", stat_lockev, 0);
    chk("R12 stat_batrst", stat_batrst, 0);

    // R1 R10: warning then ack; wrong address leaves irq
    pwr_warn_n = 0; idle(2); chk("R1 not yet", sys_irq, 0);
    idle(1); chk("R1 irq", sys_irq, 1);
    wr(4'd5, 16'hFFFF); chk("R10 other addr", sys_irq, 1);
    wr(4'd2, 16'h0); chk("R10 ack", sys_irq, 0);

    // R2 R3 R8 R5 R11: software lock, DRAM off
    wr(4'd1, 16'h0); idle(1);
    chk("R3 lockout", lockout, 1); chk("R8 lockev", stat_lockev, 1);
    chk("R5 rst", bat_rst_n, 0); chk("R5 refresh", bat_refresh, 0);
    wr(4'd3, 16'h1800); chk("R11 ignored", stat_lockev, 1);

    // R4 R5: DRAM on, refresh busy delays lockout
    do_reset(); dram_en = 1; refresh_busy = 1;
    pwr_warn_n = 0; idle(4); wr(4'd1, 16'h0); idle(30);
    chk("R4 waits", lockout, 0); chk("R10 irq pending", sys_irq, 1);
    refresh_busy = 0; idle(1); chk("R4 locked", lockout, 1);
    chk("R5 irq cleared", sys_irq, 0); chk("R5 refresh", bat_refresh, 1);

    // R6: watchdog arms after TO ticks
    do_reset(); pwr_warn_n = 0; idle(4); tick_on = 1;
    idle(8 * (TO - 2)); chk("R6 early", lockout, 0);
    idle(8 * 3); chk("R6 timeout", lockout, 1); chk("R8 by timer", stat_lockev, 1);

    // R7 R9: battery pin and selective clearing
    do_reset(); bat_pin_n = 0; idle(1); bat_pin_n = 1; idle(4);
    chk("R7 batrst", stat_batrst, 1);
    wr(4'd3, 16'h0); chk("R9 zero keeps", stat_batrst, 1);
    wr(4'd3, 16'h0800); chk("R9 other bit", stat_batrst, 1);
    wr(4'd3, 16'h1000); chk("R9 cleared", stat_batrst, 0);
    idle(5);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule